// File: doc/BRIEF.md
# DMA Interrupt Pending Aggregator

This block gathers the per-channel interrupt events of a DMA engine that has two groups of channels, a general group and a peripheral-bound group. Each channel signals a half-way event and a completion event as one-cycle pulses. The block latches every pulse into a status word, masks that word with an enable word, and raises a single registered interrupt line whenever any enabled bit is pending. Software reaches both words through a small register bus. It clears status bits by writing ones.

The status word gives each channel two adjacent bits. The even bit is the half-way flag and the odd bit is the completion flag. The general group fills the lower half of the word and the peripheral-bound group fills the upper half. To help a service routine, the block also reports the lowest enabled and pending completion bit as a valid flag, a group flag and a channel number. Software can therefore handle completions from the lowest bit upward.

Top module: `dma_irq_aggregator`

## Requirements
- R1: After a synchronous reset, the status word, the enable word, `irq_o`, `rd_data_o` and `next_valid_o` are all zero.
- R2: A pulse on a channel's half-way input sets status bit 2c. A pulse on its completion input sets bit 2c+1. General channels use bits 2c and 2c+1 from bit 0. Peripheral-bound channels use the same bits offset by 2*CH_PER_GROUP (bit 16 at the default). A pulse is latched whether or not its enable bit is set.
- R3: A write to address 1 (status) clears every status bit whose write-data bit is one. Bits written with zero keep their value.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A write to address 0 (enable) loads the whole enable word with the write data.
- R6: `irq_o` is one in the cycle after a cycle in which some bit is set in both the status word and the enable word. Otherwise it is zero.
- R7: `next_valid_o` is one when some odd (completion) status bit is both pending and enabled. `next_is_dedicated_o` and `next_channel_o` then name the lowest such bit: the group is 1 for the upper half, and the channel is (bit/2) mod CH_PER_GROUP. Half-way bits never affect these outputs. The outputs follow the registers with no added latency.
- R8: A read (`bus_sel_i`=1, `bus_we_i`=0) returns the addressed word on `rd_data_o` in the next cycle. Address 0 returns enable and address 1 returns status. Any other address returns zero, and writes to any other address change nothing. Between reads, `rd_data_o` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_half_i | input | CH_PER_GROUP | Half-way pulses, general group |
| gen_end_i | input | CH_PER_GROUP | Completion pulses, general group |
| ded_half_i | input | CH_PER_GROUP | Half-way pulses, peripheral-bound group |
| ded_end_i | input | CH_PER_GROUP | Completion pulses, peripheral-bound group |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | 4*CH_PER_GROUP | Write data |
| rd_data_o | output | 4*CH_PER_GROUP | Registered read data |
| irq_o | output | 1 | Combined interrupt, registered |
| next_valid_o | output | 1 | A completion bit is pending and enabled |
| next_is_dedicated_o | output | 1 | Group of the lowest such bit |
| next_channel_o | output | $clog2(CH_PER_GROUP) | Channel of the lowest such bit |

## Verification
The bench builds the block with its defaults: eight channels per group, a 32-bit word and a two-bit address. With these values it covers the boundary between bit 15 and bit 16, where the group flag flips, and the unused address codes 2 and 3, which must read zero. A behavioural model in the bench tracks the two words across directed and random traffic. This includes same-cycle collisions of an event and a clear, and a mix of half-way and completion bits in which the priority pick must skip the half-way bits.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned ADDR_ENABLE = 0;
  localparam int unsigned ADDR_STATUS = 1;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } bus_op_e;
endpackage

// File: rtl/dma_irq_pend_bank.sv
module dma_irq_pend_bank #(
  parameter int unsigned STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] set_vec,
  input  logic [STAT_W-1:0] clr_vec,
  output logic [STAT_W-1:0] pend_q
);
  genvar b;
  generate
    for (b = 0; b < STAT_W; b++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)
          pend_q[b] <= 1'b0;
        else if (set_vec[b])
          pend_q[b] <= 1'b1;
        else if (clr_vec[b])
          pend_q[b] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/dma_irq_regif.sv
module dma_irq_regif
  import dma_irq_pkg::*;
#(
  parameter int unsigned STAT_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [STAT_W-1:0] wdata,
  input  logic [STAT_W-1:0] pend_q,
  output logic [STAT_W-1:0] en_q,
  output logic [STAT_W-1:0] clr_vec,
  output logic [STAT_W-1:0] rdata_q
);
  bus_op_e op;
  logic    hit_en;
  logic    hit_st;

  always_comb begin
    if (!sel)    op = OP_IDLE;
    else if (we) op = OP_WRITE;
    else         op = OP_READ;
    hit_en  = (addr == ADDR_W'(ADDR_ENABLE));
    hit_st  = (addr == ADDR_W'(ADDR_STATUS));
    clr_vec = (op == OP_WRITE && hit_st) ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst)
      en_q <= '0;
    else if (op == OP_WRITE && hit_en)
      en_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (op == OP_READ) begin
      if (hit_en)      rdata_q <= en_q;
      else if (hit_st) rdata_q <= pend_q;
      else             rdata_q <= '0;
    end
  end
endmodule

// File: rtl/dma_irq_pick.sv
module dma_irq_pick #(
  parameter int unsigned CH_PER_GROUP = 8,
  localparam int unsigned STAT_W = 4 * CH_PER_GROUP,
  localparam int unsigned NCH    = 2 * CH_PER_GROUP,
  localparam int unsigned CHW    = $clog2(CH_PER_GROUP)
) (
  input  logic [STAT_W-1:0] pend_q,
  input  logic [STAT_W-1:0] en_q,
  output logic              valid,
  output logic              is_ded,
  output logic [CHW-1:0]    chan
);
  logic [NCH-1:0] done_req;

  genvar k;
  generate
    for (k = 0; k < NCH; k++) begin : g_req
      assign done_req[k] = pend_q[2*k+1] & en_q[2*k+1];
    end
  endgenerate

  always_comb begin
    valid  = 1'b0;
    is_ded = 1'b0;
    chan   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (done_req[i]) begin
        valid  = 1'b1;
        is_ded = (i >= CH_PER_GROUP);
        chan   = CHW'(i % CH_PER_GROUP);
      end
    end
  end
endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator #(
  parameter int unsigned CH_PER_GROUP = 8,
  parameter int unsigned ADDR_W       = 2,
  localparam int unsigned STAT_W = 4 * CH_PER_GROUP,
  localparam int unsigned HALF_W = 2 * CH_PER_GROUP,
  localparam int unsigned CHW    = $clog2(CH_PER_GROUP)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CH_PER_GROUP-1:0] gen_half_i,
  input  logic [CH_PER_GROUP-1:0] gen_end_i,
  input  logic [CH_PER_GROUP-1:0] ded_half_i,
  input  logic [CH_PER_GROUP-1:0] ded_end_i,
  input  logic                    bus_sel_i,
  input  logic                    bus_we_i,
  input  logic [ADDR_W-1:0]       bus_addr_i,
  input  logic [STAT_W-1:0]       bus_wdata_i,
  output logic [STAT_W-1:0]       rd_data_o,
  output logic                    irq_o,
  output logic                    next_valid_o,
  output logic                    next_is_dedicated_o,
  output logic [CHW-1:0]          next_channel_o
);
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] pend_q;
  logic [STAT_W-1:0] en_q;

  genvar c;
  generate
    for (c = 0; c < CH_PER_GROUP; c++) begin : g_pack
      assign set_vec[2*c]            = gen_half_i[c];
      assign set_vec[2*c+1]          = gen_end_i[c];
      assign set_vec[HALF_W+2*c]     = ded_half_i[c];
      assign set_vec[HALF_W+2*c+1]   = ded_end_i[c];
    end
  endgenerate

  dma_irq_pend_bank #(.STAT_W(STAT_W)) u_bank (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec), .pend_q(pend_q)
  );

  dma_irq_regif #(.STAT_W(STAT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .sel(bus_sel_i), .we(bus_we_i), .addr(bus_addr_i),
    .wdata(bus_wdata_i), .pend_q(pend_q), .en_q(en_q), .clr_vec(clr_vec),
    .rdata_q(rd_data_o)
  );

  dma_irq_pick #(.CH_PER_GROUP(CH_PER_GROUP)) u_pick (
    .pend_q(pend_q), .en_q(en_q), .valid(next_valid_o),
    .is_ded(next_is_dedicated_o), .chan(next_channel_o)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(pend_q & en_q);
  end
endmodule

// File: rtl/dma_irq_chk.sv
module dma_irq_chk #(
  parameter int unsigned CH_PER_GROUP = 8,
  parameter int unsigned ADDR_W       = 2,
  localparam int unsigned STAT_W = 4 * CH_PER_GROUP,
  localparam int unsigned HALF_W = 2 * CH_PER_GROUP,
  localparam int unsigned CHW    = $clog2(CH_PER_GROUP)
) (
  input logic                    clk,
  input logic                    rst,
  input logic [CH_PER_GROUP-1:0] gen_half_i,
  input logic [CH_PER_GROUP-1:0] gen_end_i,
  input logic [CH_PER_GROUP-1:0] ded_half_i,
  input logic [CH_PER_GROUP-1:0] ded_end_i,
  input logic                    bus_sel_i,
  input logic                    bus_we_i,
  input logic [ADDR_W-1:0]       bus_addr_i,
  input logic [STAT_W-1:0]       bus_wdata_i,
  input logic [STAT_W-1:0]       rd_data_o,
  input logic                    irq_o,
  input logic                    next_valid_o,
  input logic                    next_is_dedicated_o,
  input logic [CHW-1:0]          next_channel_o,
  input logic [STAT_W-1:0]       pend_q,
  input logic [STAT_W-1:0]       en_q
);
  logic [STAT_W-1:0] ev;
  logic [STAT_W-1:0] wipe;
  logic [STAT_W-1:0] odd_mask;
  int                pick_pos;

  always_comb begin
    for (int c = 0; c < CH_PER_GROUP; c++) begin
      ev[2*c]          = gen_half_i[c];
      ev[2*c+1]        = gen_end_i[c];
      ev[HALF_W+2*c]   = ded_half_i[c];
      ev[HALF_W+2*c+1] = ded_end_i[c];
    end
    for (int b = 0; b < STAT_W; b++) odd_mask[b] = b[0];
    wipe = (bus_sel_i && bus_we_i && bus_addr_i == ADDR_W'(1)) ? (bus_wdata_i & ~ev) : '0;
    pick_pos = (next_is_dedicated_o ? HALF_W : 0) + 2 * int'(next_channel_o) + 1;
  end

  // R1
  reset_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pend_q == '0 && en_q == '0 && !irq_o && rd_data_o == '0));

  // R2
  event_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (ev != '0) |=> ((pend_q & $past(ev)) == $past(ev)));

  // R3
  clear_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (wipe != '0) |=> ((pend_q & $past(wipe)) == '0));

  // R5
  enable_load_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel_i && bus_we_i && bus_addr_i == ADDR_W'(0)) |=> (en_q == $past(bus_wdata_i)));

  // R6
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_o == $past(|(pend_q & en_q))));

  // R7
  pick_hit_chk: assert property (@(posedge clk) disable iff (rst)
    next_valid_o |-> (pend_q[pick_pos] && en_q[pick_pos]));

  // R7
  pick_none_chk: assert property (@(posedge clk) disable iff (rst)
    !next_valid_o |-> ((pend_q & en_q & odd_mask) == '0));

  // R8
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel_i && !bus_we_i && bus_addr_i > ADDR_W'(1)) |=> (rd_data_o == '0));
endmodule

bind dma_irq_aggregator dma_irq_chk #(.CH_PER_GROUP(CH_PER_GROUP), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .gen_half_i(gen_half_i), .gen_end_i(gen_end_i),
  .ded_half_i(ded_half_i), .ded_end_i(ded_end_i), .bus_sel_i(bus_sel_i),
  .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
  .rd_data_o(rd_data_o), .irq_o(irq_o), .next_valid_o(next_valid_o),
  .next_is_dedicated_o(next_is_dedicated_o), .next_channel_o(next_channel_o),
  .pend_q(pend_q), .en_q(en_q)
);

// File: tb/sim_dma_irq_aggregator.sv
module sim_dma_irq_aggregator;
  localparam int CLK_PERIOD = 10;
  localparam int CH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  gh = '0, ge = '0, dh = '0, de = '0;
  logic        sel = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, nv, nd;
  logic [2:0]  nc;

  int total = 0;
  int bad   = 0;
  bit live  = 0;

  logic [31:0] m_pend = '0, m_en = '0, m_rd = '0;
  logic        m_irq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_aggregator #(.CH_PER_GROUP(CH), .ADDR_W(2)) u0 (
    .clk(clk), .rst(rst), .gen_half_i(gh), .gen_end_i(ge), .ded_half_i(dh),
    .ded_end_i(de), .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .rd_data_o(rdata), .irq_o(irq), .next_valid_o(nv),
    .next_is_dedicated_o(nd), .next_channel_o(nc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: evolves with each edge.
  always @(posedge clk) begin
    logic [31:0] evv, clr;
    if (rst) begin
      m_pend = '0; m_en = '0; m_rd = '0; m_irq = 1'b0;
    end else begin
      for (int c = 0; c < CH; c++) begin
        evv[2*c] = gh[c]; evv[2*c+1] = ge[c];
        evv[16+2*c] = dh[c]; evv[16+2*c+1] = de[c];
      end
      clr = (sel && we && addr == 2'd1) ? wdata : '0;
      m_irq = |(m_pend & m_en);
      if (sel && !we) m_rd = (addr == 2'd0) ? m_en : (addr == 2'd1) ? m_pend : '0;
      m_pend = (m_pend & ~clr) | evv;
      if (sel && we && addr == 2'd0) m_en = wdata;
    end
  end

  function automatic logic [31:0] model_next();
    logic [31:0] r = '0;
    for (int b = 31; b >= 1; b -= 2)
      if (m_pend[b] && m_en[b]) r = {27'b0, 1'b1, (b >= 16), 3'((b / 2) % CH)};
    return r;
  endfunction

  always @(negedge clk) begin
    if (live) begin
      chk("R6 irq", {31'b0, irq}, {31'b0, m_irq});
      chk("R8 rdata", rdata, m_rd);
      chk("R7 next", {27'b0, nv, nd, nc}, model_next());
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); sel = 1; we = 0; addr = a;
    @(negedge clk); sel = 0;
    chk(tag, rdata, exp);
  endtask

  task automatic pulse(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, input logic [7:0] d);
    @(negedge clk); gh = a; ge = b; dh = c; de = d;
    @(negedge clk); gh = 0; ge = 0; dh = 0; de = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; live = 1;
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 next_valid", {31'b0, nv}, 0);
    chk("R1 rdata", rdata, 0);
    bus_rd(2'd1, 32'h0, "R1 status");
    bus_rd(2'd0, 32'h0, "R1 enable");
    // R2 latching with enables off
    pulse(8'h00, 8'h01, 8'h00, 8'h00);
    bus_rd(2'd1, 32'h0000_0002, "R2 gen ch0 end -> bit1");
    pulse(8'h00, 8'h00, 8'h80, 8'h00);
    bus_rd(2'd1, 32'h4000_0002, "R2 ded ch7 half -> bit30");
    chk("R6 masked irq", {31'b0, irq}, 0);
    // R5 enable
    bus_wr(2'd0, 32'hFFFF_FFFF);
    bus_rd(2'd0, 32'hFFFF_FFFF, "R5 enable load");
    chk("R7 gen ch0", {27'b0, nv, nd, nc}, {27'b0, 1'b1, 1'b0, 3'd0});
    chk("R6 irq up", {31'b0, irq}, 1);
    // R3 clear ones only
    bus_wr(2'd1, 32'h0000_0002);
    bus_rd(2'd1, 32'h4000_0000, "R3 selective clear");
    chk("R7 half ignored", {31'b0, nv}, 0);
    chk("R6 irq from half bit", {31'b0, irq}, 1);
    // R7 ordering across groups
    pulse(8'h00, 8'h00, 8'h00, 8'h08);
    chk("R7 ded ch3", {27'b0, nv, nd, nc}, {27'b0, 1'b1, 1'b1, 3'd3});
    pulse(8'h00, 8'h20, 8'h00, 8'h00);
    chk("R7 gen ch5 beats ded", {27'b0, nv, nd, nc}, {27'b0, 1'b1, 1'b0, 3'd5});
    // R4 event wins over simultaneous clear
    @(negedge clk); sel = 1; we = 1; addr = 2'd1; wdata = 32'h0000_0800; ge = 8'h20;
    @(negedge clk); sel = 0; we = 0; ge = 0;
    bus_rd(2'd1, 32'h4080_0800, "R4 collision keeps bit11");
    // R3 clear all
    bus_wr(2'd1, 32'hFFFF_FFFF);
    bus_rd(2'd1, 32'h0, "R3 clear all");
    @(negedge clk);
    chk("R6 irq down", {31'b0, irq}, 0);
    // R8 unmapped
    bus_wr(2'd2, 32'hFFFF_FFFF);
    bus_wr(2'd3, 32'hFFFF_FFFF);
    bus_rd(2'd2, 32'h0, "R8 unmapped read");
    bus_rd(2'd0, 32'hFFFF_FFFF, "R8 enable untouched");
    bus_rd(2'd1, 32'h0, "R8 status untouched");
    // mixed random traffic checked against the model
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      gh = ($urandom % 4 == 0) ? 8'($urandom) & 8'($urandom) : 8'h0;
      ge = ($urandom % 4 == 0) ? 8'($urandom) & 8'($urandom) : 8'h0;
      dh = ($urandom % 4 == 0) ? 8'($urandom) & 8'($urandom) : 8'h0;
      de = ($urandom % 4 == 0) ? 8'($urandom) & 8'($urandom) : 8'h0;
      sel = ($urandom % 3 == 0);
      we = $urandom % 2;
      addr = 2'($urandom);
      wdata = $urandom;
    end
    @(negedge clk); sel = 0; gh = 0; ge = 0; dh = 0; de = 0;
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule